// File: doc/BRIEF.md
# Two-Phase Steered Pulse-Width Modulator

This block is a fixed-frequency digital pulse-width modulator that drives two power switches in alternation. A free-running counter forms the ramp. Each period opens with a blanking window, brought out as a period pulse. During that window both drives are held off, which gives the dead time between the two switches. A phase flip-flop flips at every period start, so consecutive modulated pulses go to drive A and then drive B. After the window, the selected drive stays on while the ramp count is below the latched duty command.

Three overrides cut the pulse. A shutdown input kills both drives in the same cycle. A current-limit flag ends the pulse early, and it stays ended for the rest of that period. A rising edge on the sync input restarts the period at once, so that several units can follow one master. A gang-mode input makes both drives carry the same pulse in every period, so that they can be wired together as one switch. The duty command and the blanking width are taken only at a period start. A blanking width outside the allowed range is refused.

Top module: `pp_pwm_ctrl`

## Requirements
- R1: While reset is asserted, drv_a_o, drv_b_o and per_o are 0. The first period after reset release starts on the first clock edge and steers its pulse to drive A.
- R2: A period lasts PERIOD clock cycles (count 0 to PERIOD-1). per_o is 1 exactly while the count is below the latched blanking width, so it is high for that many cycles at the start of each period.
- R3: While per_o is 1, both drives are 0.
- R4: With gang mode off, periods alternate between drive A and drive B, starting a new phase at every period start, and the two drives are never 1 together.
- R5: The active drive is 1 exactly in the cycles where the blanking width is at or below the count and the count is below the latched duty. Its pulse width is therefore min(duty, PERIOD) minus blank when that value is positive, and 0 otherwise.
- R6: A duty at or below the blanking width gives no pulse. A duty at or above PERIOD keeps the drive on until the last count of the period.
- R7: With gang_i = 1, both drives carry the same pulse in every period.
- R8: While shdn_i is 1, both drives are 0 in the same cycle.
- R9: A cycle with ilim_i = 1 forces both drives to 0 in that cycle and for the rest of the period. The next period has its full width.
- R10: A rising edge of sync_i sampled at a clock edge restarts the period at that edge: the count goes to 0, per_o goes to 1 and the phase flips.
- R11: A blanking width below BLANK_MIN (2) or above BLANK_MAX (20) is refused at the period start, and the previous width stays in use.
- R12: duty_i and blank_i are sampled only at a period start. A change in the middle of a period does not alter the pulse of that period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| duty_i | input | CNT_W (7) | Duty command, compared with the ramp count |
| blank_i | input | BLK_W (5) | Blanking width in cycles |
| shdn_i | input | 1 | Shutdown, forces both drives off |
| ilim_i | input | 1 | Current-limit flag |
| sync_i | input | 1 | Period restart on rising edge |
| gang_i | input | 1 | Gang mode: both drives carry every pulse |
| drv_a_o | output | 1 | Drive A |
| drv_b_o | output | 1 | Drive B |
| per_o | output | 1 | Period pulse, high during the blanking window |

## Verification
Two events can land in the same cycle in this block. A sync edge in the middle of a period restarts the ramp and flips the phase flip-flop at that edge, while the drive of the current period is still on. The bench raises sync_i during the live pulse of drive A. One cycle later it checks that the period pulse is high. After the blanking window it checks that drive B, not drive A, takes the pulse. A current-limit hit during a live pulse is judged the same way: the bench checks that the drives drop in that cycle, stay low for the rest of the period, and recover to the full width in the next period.

// File: rtl/pp_pwm_pkg.sv
package pp_pwm_pkg;
  // Which drive the phase flip-flop currently selects
  typedef enum logic {
    SIDE_A = 1'b0,
    SIDE_B = 1'b1
  } side_e;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int PERIOD = 64,
  parameter int CNT_W  = $clog2(PERIOD + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             start_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sync_q, sync_rise;

  assign sync_rise = sync_i & ~sync_q;
  assign start_o   = (cnt_q == LAST) | sync_rise;

  always_comb begin
    if (start_o) cnt_d = '0;
    else         cnt_d = cnt_q + CNT_W'(1);
  end

  // Reset parks the count on its last value so the first edge opens a period
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= LAST;
      sync_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sync_q <= sync_i;
    end
  end

  assign cnt_o = cnt_q;

  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == LAST) |=> (cnt_q == '0));
  assert_sync_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_i && !sync_q) |=> (cnt_q == '0));
endmodule

// File: rtl/pwm_cmd_latch.sv
module pwm_cmd_latch #(
  parameter int CNT_W     = 7,
  parameter int BLK_W     = 5,
  parameter int BLANK_MIN = 2,
  parameter int BLANK_MAX = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [BLK_W-1:0] blank_i,
  output logic [CNT_W-1:0] duty_o,
  output logic [BLK_W-1:0] blank_o
);
  localparam logic [BLK_W-1:0] BMIN = BLK_W'(BLANK_MIN);
  localparam logic [BLK_W-1:0] BMAX = BLK_W'(BLANK_MAX);

  logic [CNT_W-1:0] duty_q, duty_d;
  logic [BLK_W-1:0] blank_q, blank_d;
  logic             blank_ok;

  assign blank_ok = (blank_i >= BMIN) && (blank_i <= BMAX);

  always_comb begin
    duty_d  = duty_q;
    blank_d = blank_q;
    if (start_i) begin
      duty_d = duty_i;
      if (blank_ok) blank_d = blank_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q  <= '0;
      blank_q <= BMIN;
    end else begin
      duty_q  <= duty_d;
      blank_q <= blank_d;
    end
  end

  assign duty_o  = duty_q;
  assign blank_o = blank_q;

  assert_blank_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_q >= BMIN) && (blank_q <= BMAX));
  assert_hold_mid_period_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> ($stable(duty_q) && $stable(blank_q)));
endmodule

// File: rtl/pwm_steer_gate.sv
module pwm_steer_gate
  import pp_pwm_pkg::*;
#(
  parameter int CNT_W = 7,
  parameter int BLK_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [BLK_W-1:0] blank_i,
  input  logic             shdn_i,
  input  logic             ilim_i,
  input  logic             gang_i,
  output logic             drv_a_o,
  output logic             drv_b_o,
  output logic             per_o
);
  localparam int CMP_W = (CNT_W > BLK_W) ? CNT_W : BLK_W;

  side_e steer_q, steer_d;
  logic  lim_q, lim_d;
  logic  window, kill, drive;

  // Phase flips at each period start; reset value makes the first period side A
  always_comb begin
    steer_d = steer_q;
    if (start_i) steer_d = (steer_q == SIDE_A) ? SIDE_B : SIDE_A;
  end

  // Current-limit latch lives for the rest of the period
  always_comb begin
    if (start_i) lim_d = 1'b0;
    else         lim_d = lim_q | ilim_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      steer_q <= SIDE_B;
      lim_q   <= 1'b0;
    end else begin
      steer_q <= steer_d;
      lim_q   <= lim_d;
    end
  end

  assign per_o   = CMP_W'(cnt_i) < CMP_W'(blank_i);
  assign window  = ~per_o & (cnt_i < duty_i);
  assign kill    = shdn_i | ilim_i | lim_q;
  assign drive   = window & ~kill;
  assign drv_a_o = drive & (gang_i | (steer_q == SIDE_A));
  assign drv_b_o = drive & (gang_i | (steer_q == SIDE_B));

  assert_blank_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    per_o |-> (!drv_a_o && !drv_b_o));
  assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !gang_i |-> !(drv_a_o && drv_b_o));
  assert_phase_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (steer_q != $past(steer_q)));
  assert_shutdown_R8: assert property (@(posedge clk) disable iff (!rst_n)
    shdn_i |-> (!drv_a_o && !drv_b_o));
  assert_limit_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ilim_i && !start_i) |=> (!drv_a_o && !drv_b_o));
  assert_gang_same_R7: assert property (@(posedge clk) disable iff (!rst_n)
    gang_i |-> (drv_a_o == drv_b_o));
endmodule

// File: rtl/pp_pwm_ctrl.sv
module pp_pwm_ctrl #(
  parameter int PERIOD    = 64,
  parameter int BLANK_MIN = 2,
  parameter int BLANK_MAX = 20,
  parameter int CNT_W     = $clog2(PERIOD + 1),
  parameter int BLK_W     = $clog2(BLANK_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [BLK_W-1:0] blank_i,
  input  logic             shdn_i,
  input  logic             ilim_i,
  input  logic             sync_i,
  input  logic             gang_i,
  output logic             drv_a_o,
  output logic             drv_b_o,
  output logic             per_o
);
  logic [CNT_W-1:0] cnt;
  logic             start;
  logic [CNT_W-1:0] duty_l;
  logic [BLK_W-1:0] blank_l;

  pwm_timebase #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .cnt_o(cnt), .start_o(start)
  );

  pwm_cmd_latch #(.CNT_W(CNT_W), .BLK_W(BLK_W), .BLANK_MIN(BLANK_MIN),
                  .BLANK_MAX(BLANK_MAX)) u_cmd (
    .clk(clk), .rst_n(rst_n), .start_i(start), .duty_i(duty_i),
    .blank_i(blank_i), .duty_o(duty_l), .blank_o(blank_l)
  );

  pwm_steer_gate #(.CNT_W(CNT_W), .BLK_W(BLK_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cnt_i(cnt), .duty_i(duty_l),
    .blank_i(blank_l), .shdn_i(shdn_i), .ilim_i(ilim_i), .gang_i(gang_i),
    .drv_a_o(drv_a_o), .drv_b_o(drv_b_o), .per_o(per_o)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!drv_a_o && !drv_b_o));
endmodule

// File: tb/pp_pwm_ctrl_tb.sv
`timescale 1ns/1ps
module pp_pwm_ctrl_tb;
  localparam int P = 64;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [6:0] duty_i;
  logic [4:0] blank_i;
  logic       shdn_i, ilim_i, sync_i, gang_i;
  logic       drv_a_o, drv_b_o, per_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  pp_pwm_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .duty_i(duty_i), .blank_i(blank_i),
    .shdn_i(shdn_i), .ilim_i(ilim_i), .sync_i(sync_i), .gang_i(gang_i),
    .drv_a_o(drv_a_o), .drv_b_o(drv_b_o), .per_o(per_o)
  );

  // {duty[6:0], blank[4:0], gang, width[6:0]}
  localparam logic [19:0] VEC [8] = '{
    {7'd30,  5'd4,  1'b0, 7'd26},
    {7'd4,   5'd4,  1'b0, 7'd0 },
    {7'd3,   5'd6,  1'b0, 7'd0 },
    {7'd64,  5'd4,  1'b0, 7'd60},
    {7'd127, 5'd10, 1'b0, 7'd54},
    {7'd20,  5'd2,  1'b1, 7'd18},
    {7'd5,   5'd4,  1'b0, 7'd1 },
    {7'd63,  5'd20, 1'b0, 7'd43}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Returns at the first negedge where per_o has just risen (count 0)
  task automatic wait_rise();
    bit prev = 1'b1;
    forever begin
      @(negedge clk);
      if (per_o && !prev) break;
      prev = per_o;
    end
  endtask

  task automatic measure(input int nper, output int ca, output int cb,
                         output int cp, output int ov);
    ca = 0; cb = 0; cp = 0; ov = 0;
    for (int i = 0; i < nper * P; i++) begin
      ca += int'(drv_a_o);
      cb += int'(drv_b_o);
      cp += int'(per_o);
      ov += int'(drv_a_o & drv_b_o);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int ca, cb, cp, ov, w;
    bit side_a;
    rst_n = 1'b0; duty_i = 7'd30; blank_i = 5'd4;
    shdn_i = 0; ilim_i = 0; sync_i = 0; gang_i = 0;
    repeat (3) @(negedge clk);
    // R1: quiet in reset
    chk("R1 reset drives", int'(drv_a_o | drv_b_o), 0);
    chk("R1 reset per", int'(per_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 period opens after reset", int'(per_o), 1);
    repeat (4) @(negedge clk);
    chk("R1 first pulse on A", int'(drv_a_o), 1);
    chk("R1 first pulse not B", int'(drv_b_o), 0);

    // Table walk: R5 R6 R7 R4 R2 R3
    foreach (VEC[k]) begin
      duty_i  = VEC[k][19:13];
      blank_i = VEC[k][12:8];
      gang_i  = VEC[k][7];
      w       = int'(VEC[k][6:0]);
      wait_rise();
      measure(2, ca, cb, cp, ov);
      if (gang_i) begin
        chk("R7 gang A width", ca, 2 * w);
        chk("R7 gang B width", cb, 2 * w);
      end else begin
        chk("R5 R6 A width", ca, w);
        chk("R5 R6 B width", cb, w);
        chk("R4 overlap", ov, 0);
      end
      chk("R2 R3 blank cycles", cp, 2 * int'(blank_i));
    end
    gang_i = 0;

    // R8: shutdown mid-pulse
    duty_i = 7'd30; blank_i = 5'd4;
    wait_rise();
    repeat (5) @(negedge clk);
    chk("R8 pulse live before", int'(drv_a_o | drv_b_o), 1);
    shdn_i = 1; #1;
    chk("R8 shutdown same cycle", int'(drv_a_o | drv_b_o), 0);
    @(negedge clk);
    chk("R8 shutdown held", int'(drv_a_o | drv_b_o), 0);
    shdn_i = 0;

    // R9: current limit ends pulse, next period full
    wait_rise();
    repeat (7) @(negedge clk);
    chk("R9 pulse live before", int'(drv_a_o | drv_b_o), 1);
    ilim_i = 1; #1;
    chk("R9 limit same cycle", int'(drv_a_o | drv_b_o), 0);
    @(negedge clk);
    ilim_i = 0;
    ov = 0;
    for (int i = 0; i < 6; i++) begin
      ov += int'(drv_a_o | drv_b_o);
      @(negedge clk);
    end
    chk("R9 limit rest of period", ov, 0);
    wait_rise();
    measure(1, ca, cb, cp, ov);
    chk("R9 next period full", ca + cb, 26);

    // R10: sync edge during live pulse flips phase and restarts
    wait_rise();
    repeat (4) @(negedge clk);
    side_a = drv_a_o;
    chk("R10 pulse live before", int'(drv_a_o | drv_b_o), 1);
    sync_i = 1;
    @(negedge clk);
    sync_i = 0;
    chk("R10 restart per", int'(per_o), 1);
    repeat (4) @(negedge clk);
    chk("R10 phase flipped A", int'(drv_a_o), int'(!side_a));
    chk("R10 phase flipped B", int'(drv_b_o), int'(side_a));

    // R11: out-of-range blanking refused
    blank_i = 5'd1;
    wait_rise();
    measure(1, ca, cb, cp, ov);
    chk("R11 below min refused", cp, 4);
    blank_i = 5'd25;
    wait_rise();
    measure(1, ca, cb, cp, ov);
    chk("R11 above max refused", cp, 4);
    blank_i = 5'd8;
    wait_rise();
    measure(1, ca, cb, cp, ov);
    chk("R11 legal width taken", cp, 8);

    // R12: mid-period command change has no effect on this period
    duty_i = 7'd20; blank_i = 5'd4;
    wait_rise();
    duty_i = 7'd40; blank_i = 5'd10;
    measure(1, ca, cb, cp, ov);
    chk("R12 duty held", ca + cb, 16);
    chk("R12 blank held", cp, 4);
    measure(1, ca, cb, cp, ov);
    chk("R12 new duty next period", ca + cb, 30);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule